// File: doc/BRIEF.md
# SIMD Divergence Mask Stack

This block tracks which lanes of a SIMD group are allowed to commit results while the group runs through nested, divergent branches. All lanes fetch and execute every instruction; the block only decides, lane by lane, whether a result may be written back. At a divergent branch the sequencer issues a push. The current mask is saved on a small LIFO, and the new mask keeps only those lanes that were active and whose branch predicate is set. A complement command at the start of the other path switches to the remaining lanes of the enclosing scope. A pop at the reconvergence point brings back the saved mask.

The number of lanes and the nesting depth are parameters, with 16 lanes and 8 levels by default. A push that finds the stack full, or a pop that finds it empty, changes nothing and raises a one-cycle flag. A clear command returns the block to its reset state without a reset pulse.

Top module: `divmask_stack`

## Requirements
- R1: After reset the mask has every lane active, the stack is empty, and both flags are low.
- R2: A push (command code 1) with a non-full stack saves the current mask and, from the next cycle, the mask is the old mask AND the predicate input.
- R3: A complement (code 2) sets the mask to the top saved mask AND the inverse of the current mask, so lanes inactive before the branch stay inactive.
- R4: A pop (code 3) with a non-empty stack restores the most recently saved mask and removes it from the stack.
- R5: Each lane's write enable equals that lane's mask bit AND the write-request input, in the same cycle, with no register in between.
- R6: A push while DEPTH masks are saved raises the overflow flag for exactly the next cycle and changes neither the mask nor the stack.
- R7: A pop with an empty stack raises the underflow flag for exactly the next cycle and changes neither the mask nor the stack.
- R8: A clear (code 4) makes every lane active and empties the stack from the next cycle.
- R9: A complement with an empty stack uses an all-active saved mask, so the mask becomes its own inverse.
- R10: Code 0 and codes 5 to 7 leave mask and stack unchanged; every command other than a failing push or pop leaves both flags low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 idle, 1 push, 2 complement, 3 pop, 4 clear |
| pred_i | input | LANES | Per-lane branch predicate, used by push |
| wb_req_i | input | 1 | The current instruction wants to write a result |
| mask_o | output | LANES | Active-lane mask |
| lane_we_o | output | LANES | Per-lane result write enable |
| overflow_o | output | 1 | Push was refused because the stack was full |
| underflow_o | output | 1 | Pop was refused because the stack was empty |

## Verification
The bench builds the block with its defaults, 16 lanes and 8 levels. The shallow stack lets short directed runs reach the full and empty boundaries, refused pushes and pops included. The 16-lane predicates make nested complements produce masks where inactive outer lanes must stay off. A long run of random commands, weighted toward push and pop, then walks depth up and down across the whole range many times.

// File: rtl/divmask_pkg.sv
package divmask_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_PUSH  = 3'd1,
        CMD_COMP  = 3'd2,
        CMD_POP   = 3'd3,
        CMD_CLEAR = 3'd4
    } dm_cmd_e;

    localparam int DM_LANES_DEF = 16;
    localparam int DM_DEPTH_DEF = 8;

endpackage

// File: rtl/divmask_store.sv
module divmask_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);

    logic [WIDTH-1:0] ent_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[e] <= '0;
            end else if (wr_en_i && (wr_idx_i == IW'(e))) begin
                ent_q[e] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = ent_q[rd_idx_i];

endmodule

// File: rtl/divmask_ctrl.sv
module divmask_ctrl
    import divmask_pkg::*;
#(
    parameter int LANES = DM_LANES_DEF,
    parameter int DEPTH = DM_DEPTH_DEF,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] top_i,
    output logic [LANES-1:0] mask_o,
    output logic [DW-1:0]    depth_o,
    output logic             push_o,
    output logic [IW-1:0]    wr_idx_o,
    output logic [IW-1:0]    rd_idx_o,
    output logic             ovf_o,
    output logic             unf_o
);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [DW-1:0]    depth;
        logic             ovf;
        logic             unf;
    } st_t;

    st_t              st_d, st_q;
    dm_cmd_e          cmd;
    logic [LANES-1:0] saved;
    logic [DW-1:0]    depth_m1;
    logic             full, empty;

    assign cmd      = dm_cmd_e'(cmd_i);
    assign full     = (st_q.depth == DW'(DEPTH));
    assign empty    = (st_q.depth == '0);
    assign depth_m1 = st_q.depth - DW'(1);
    assign saved    = empty ? '1 : top_i;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        push_o   = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                if (full) begin
                    st_d.ovf = 1'b1;
                end else begin
                    push_o     = 1'b1;
                    st_d.mask  = st_q.mask & pred_i;
                    st_d.depth = st_q.depth + DW'(1);
                end
            end
            CMD_COMP: begin
                st_d.mask = saved & ~st_q.mask;
            end
            CMD_POP: begin
                if (empty) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.mask  = top_i;
                    st_d.depth = depth_m1;
                end
            end
            CMD_CLEAR: begin
                st_d.mask  = '1;
                st_d.depth = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.depth <= '0;
            st_q.ovf   <= 1'b0;
            st_q.unf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o   = st_q.mask;
    assign depth_o  = st_q.depth;
    assign wr_idx_o = st_q.depth[IW-1:0];
    assign rd_idx_o = depth_m1[IW-1:0];
    assign ovf_o    = st_q.ovf;
    assign unf_o    = st_q.unf;

endmodule

// File: rtl/divmask_stack.sv
module divmask_stack
    import divmask_pkg::*;
#(
    parameter int LANES = DM_LANES_DEF,
    parameter int DEPTH = DM_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic [LANES-1:0] pred_i,
    input  logic             wb_req_i,
    output logic [LANES-1:0] mask_o,
    output logic [LANES-1:0] lane_we_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    localparam int DW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0] mask_w, top_w;
    logic [DW-1:0]    depth_w;
    logic             push_w;
    logic [IW-1:0]    wr_idx_w, rd_idx_w;

    divmask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .pred_i   (pred_i),
        .top_i    (top_w),
        .mask_o   (mask_w),
        .depth_o  (depth_w),
        .push_o   (push_w),
        .wr_idx_o (wr_idx_w),
        .rd_idx_o (rd_idx_w),
        .ovf_o    (overflow_o),
        .unf_o    (underflow_o)
    );

    divmask_store #(.WIDTH(LANES), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (push_w),
        .wr_idx_i  (wr_idx_w),
        .wr_data_i (mask_w),
        .rd_idx_i  (rd_idx_w),
        .rd_data_o (top_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we_o[l] = mask_w[l] & wb_req_i;
    end

    assign mask_o = mask_w;

endmodule

// File: rtl/divmask_checker.sv
module divmask_checker #(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd,
    input logic [LANES-1:0] pred,
    input logic             wb_req,
    input logic [LANES-1:0] mask,
    input logic [LANES-1:0] lane_we,
    input logic             ovf,
    input logic             unf,
    input logic [DW-1:0]    depth,
    input logic [LANES-1:0] top
);

    a_r2_push_narrows: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && depth != DW'(DEPTH)) |=> (mask == $past(mask & pred)));

    a_r4_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3 && depth != '0) |=> (mask == $past(top) && depth == $past(depth) - DW'(1)));

    a_r5_we_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_we & ~mask) == '0) && (wb_req || lane_we == '0));

    a_r6_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd1 && depth == DW'(DEPTH)) |=> (ovf && $stable(mask) && $stable(depth)));

    a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd3 && depth == '0) |=> (unf && $stable(mask) && $stable(depth)));

    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4) |=> (mask == '1 && depth == '0 && !ovf && !unf));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

endmodule

bind divmask_stack divmask_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_divmask_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_i),
    .pred    (pred_i),
    .wb_req  (wb_req_i),
    .mask    (mask_o),
    .lane_we (lane_we_o),
    .ovf     (overflow_o),
    .unf     (underflow_o),
    .depth   (depth_w),
    .top     (top_w)
);

// File: tb/test_divmask_stack.sv
module test_divmask_stack;

    localparam int LANES = 16;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [LANES-1:0] pred = '0;
    logic             wb_req = 1'b0;
    logic [LANES-1:0] mask, lane_we;
    logic             ovf, unf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural reference
    logic [LANES-1:0] m_mask;
    logic [LANES-1:0] m_stack [$];
    logic             m_ovf, m_unf;

    always #2 clk = ~clk;

    divmask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_divmask_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .pred_i      (pred),
        .wb_req_i    (wb_req),
        .mask_o      (mask),
        .lane_we_o   (lane_we),
        .overflow_o  (ovf),
        .underflow_o (unf)
    );

    task automatic chk(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mask_tag(input logic [2:0] c);
        case (c)
            3'd1:    return "R2 push mask";
            3'd2:    return "R3/R9 complement mask";
            3'd3:    return "R4 pop mask";
            3'd4:    return "R8 clear mask";
            default: return "R10 idle mask";
        endcase
    endfunction

    task automatic model(input logic [2:0] c, input logic [LANES-1:0] p);
        logic [LANES-1:0] sv;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        sv = (m_stack.size() == 0) ? '1 : m_stack[m_stack.size()-1];
        case (c)
            3'd1: if (m_stack.size() == DEPTH) m_ovf = 1'b1;
                  else begin m_stack.push_back(m_mask); m_mask = m_mask & p; end
            3'd2: m_mask = sv & ~m_mask;
            3'd3: if (m_stack.size() == 0) m_unf = 1'b1;
                  else m_mask = m_stack.pop_back();
            3'd4: begin m_stack.delete(); m_mask = '1; end
            default: ;
        endcase
    endtask

    // apply one command for one clock and compare every output afterwards
    task automatic step(input logic [2:0] c, input logic [LANES-1:0] p, input logic w);
        cmd = c; pred = p; wb_req = w;
        @(posedge clk);
        model(c, p);
        #1;
        chk(mask_tag(c), mask, m_mask);
        chk("R5 lane write enable", lane_we, m_mask & {LANES{w}});
        chk("R6 overflow flag", {15'd0, ovf}, {15'd0, m_ovf});
        chk("R7 underflow flag", {15'd0, unf}, {15'd0, m_unf});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        m_mask = '1; m_ovf = 1'b0; m_unf = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset mask", mask, '1);
        chk("R1 reset flags", {14'd0, ovf, unf}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: write enable combinational with wb_req, all lanes active
        step(3'd0, '0, 1'b1);
        // R2/R3/R4: if-else diamond
        step(3'd1, 16'h00FF, 1'b1);
        step(3'd2, '0, 1'b1);
        step(3'd3, '0, 1'b1);
        // nested: outer, inner, complements must keep outer-off lanes off (R3)
        step(3'd1, 16'h0F0F, 1'b0);
        step(3'd1, 16'h3333, 1'b1);
        step(3'd2, '0, 1'b1);
        step(3'd3, '0, 1'b1);
        step(3'd2, '0, 1'b1);
        step(3'd3, '0, 1'b0);
        // R9: complement on empty stack
        step(3'd2, '0, 1'b1);
        step(3'd2, '0, 1'b1);
        // R10: unused codes do nothing
        step(3'd5, 16'h1234, 1'b1);
        step(3'd6, 16'h0000, 1'b1);
        step(3'd7, 16'hFFFF, 1'b0);
        // R6: fill to DEPTH then overflow twice
        for (int i = 0; i < DEPTH; i++) step(3'd1, 16'hFFFF ^ (16'h1 << i), 1'b1);
        step(3'd1, 16'h0000, 1'b1);
        step(3'd1, 16'h0000, 1'b1);
        step(3'd0, '0, 1'b1);
        // R4 / R7: drain and underflow
        for (int i = 0; i < DEPTH; i++) step(3'd3, '0, 1'b1);
        step(3'd3, '0, 1'b1);
        step(3'd0, '0, 1'b1);
        // R8: clear from mid stack
        step(3'd1, 16'h5555, 1'b1);
        step(3'd1, 16'h0F00, 1'b1);
        step(3'd4, '0, 1'b1);
        step(3'd3, '0, 1'b1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] c;
            r = $urandom_range(0, 99);
            if (r < 35) c = 3'd1;
            else if (r < 55) c = 3'd2;
            else if (r < 88) c = 3'd3;
            else if (r < 90) c = 3'd4;
            else c = 3'($urandom_range(0, 7));
            step(c, LANES'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule